// File: doc/BRIEF.md
# Bidirectional-Port Universal Shift Register

This block is a synchronous register of `WIDTH` bits (eight by default) that can keep its contents, move them one place toward the most significant bit, move them one place toward the least significant bit, take a whole word from a parallel port, or clear itself. A two-bit mode select picks the operation. An active-low reset input is sampled on the rising clock edge and overrides the mode select.

The parallel port is one bidirectional bus. It is modelled as three signals. `busOut` always carries the register value. `busDrive` is the single enable for the drivers. `busIn` is the resolved bus value, and the register samples it during a load. The drivers switch off when either of two active-low enables is high. They also switch off by themselves whenever load mode is selected, so an outside agent can drive the bus.

Two serial inputs feed the end stages of the register. Two serial taps always show the lowest and highest bits, whatever the enables are doing. This lets several instances be chained into a longer register.

Top module: `bidir_shift_reg`

## Requirements
- R1: When `rstN` is 0 at a rising edge, every register bit becomes 0 on that edge, whatever `modeSel` and the serial inputs carry.
- R2: With `rstN` at 1 and `modeSel` = 2'b11, bit n of `busIn` is stored into bit n of the register on the rising edge.
- R3: With `rstN` at 1 and `modeSel` = 2'b01, the register moves toward the MSB: `serInLsb` enters bit 0 and bit n goes to bit n+1.
- R4: With `rstN` at 1 and `modeSel` = 2'b10, the register moves toward the LSB: `serInMsb` enters bit WIDTH-1 and bit n goes to bit n-1.
- R5: With `rstN` at 1 and `modeSel` = 2'b00, the register keeps its value, and the serial inputs and `busIn` have no effect on it.
- R6: `busDrive` is 0 whenever `enANeg` or `enBNeg` is 1.
- R7: `busDrive` is 0 whenever `modeSel` = 2'b11. It is 1 when both enables are 0 and `modeSel` is not 2'b11.
- R8: Reset, load, both shifts and hold behave as in R1 to R5 while `busDrive` is 0. `busOut` always shows the register value.
- R9: `tapLow` equals register bit 0 and `tapHigh` equals bit WIDTH-1 at all times, independent of both enables.
- R10: Two instances chained through their taps and serial inputs shift as a single register of 2*WIDTH bits, in both directions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Synchronous clear, active low, overrides the mode |
| modeSel | input | 2 | 00 hold, 01 shift toward MSB, 10 shift toward LSB, 11 load |
| serInLsb | input | 1 | Serial bit entering bit 0 on a shift toward the MSB |
| serInMsb | input | 1 | Serial bit entering the top bit on a shift toward the LSB |
| enANeg | input | 1 | Port driver enable A, active low |
| enBNeg | input | 1 | Port driver enable B, active low |
| busIn | input | WIDTH | Resolved value of the shared bus, sampled on load |
| busOut | output | WIDTH | Register value offered to the shared bus |
| busDrive | output | 1 | Drive enable for the shared bus |
| tapLow | output | 1 | Always-on copy of bit 0 |
| tapHigh | output | 1 | Always-on copy of the top bit |

## Verification
The bench loads asymmetric words such as 8'hA5, 8'h96 and 8'h3C. These show up any swapped or duplicated bit lanes. Shifts toward the MSB are run with a 1 entering and shifts toward the LSB with a 0 entering, so an input routed to the wrong end shows as an error. Hold is tried while both serial inputs are 1 and the bus carries 8'hFF with the drivers off, which exposes any leak from these inputs. Reset is applied with load and shift modes selected, to show that it has priority. A chained pair then shifts a 16-bit pattern both ways through the full 16 positions, which checks that the taps and the serial inputs join up correctly.

// File: rtl/bsr_pkg.sv
package bsr_pkg;

  typedef enum logic [1:0] {
    MODE_HOLD  = 2'b00,
    MODE_UP    = 2'b01,
    MODE_DOWN  = 2'b10,
    MODE_LOAD  = 2'b11
  } mode_e;

  // One-cycle strobes from control to datapath; at most one is set.
  typedef struct packed {
    logic clear;
    logic load;
    logic shiftUp;
    logic shiftDown;
  } strobe_t;

endpackage

// File: rtl/bsr_ctrl.sv
module bsr_ctrl
  import bsr_pkg::*;
(
  input  logic       rstN,
  input  logic [1:0] modeSel,
  input  logic       enANeg,
  input  logic       enBNeg,
  output strobe_t    strobes,
  output logic       busDrive
);

  mode_e modeNow;
  logic  enablesOn;

  assign modeNow   = mode_e'(modeSel);
  assign enablesOn = ~enANeg & ~enBNeg;

  // Reset outranks every mode; the remaining strobes are mutually exclusive.
  always_comb begin
    strobes = '0;
    if (!rstN) begin
      strobes.clear = 1'b1;
    end else begin
      unique case (modeNow)
        MODE_LOAD: strobes.load      = 1'b1;
        MODE_UP:   strobes.shiftUp   = 1'b1;
        MODE_DOWN: strobes.shiftDown = 1'b1;
        default:   strobes           = '0;
      endcase
    end
  end

  // Drivers release the bus in load mode so an outside source can drive it.
  always_comb begin
    busDrive = enablesOn;
    if (modeNow == MODE_LOAD) busDrive = 1'b0;
  end

endmodule

// File: rtl/bsr_dpath.sv
module bsr_dpath
  import bsr_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  strobe_t          strobes,
  input  logic [WIDTH-1:0] busIn,
  input  logic             serInLsb,
  input  logic             serInMsb,
  output logic [WIDTH-1:0] regQ,
  output logic             tapLow,
  output logic             tapHigh
);

  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] fromBelow;
  logic [WIDTH-1:0] fromAbove;
  logic [WIDTH-1:0] nextQ;

  for (genvar i = 0; i < WIDTH; i++) begin : g_stage
    if (i == 0) begin : g_bottom
      assign fromBelow[i] = serInLsb;
    end else begin : g_midlow
      assign fromBelow[i] = regQ[i-1];
    end

    if (i == MSB) begin : g_top
      assign fromAbove[i] = serInMsb;
    end else begin : g_midhigh
      assign fromAbove[i] = regQ[i+1];
    end

    always_comb begin
      if (strobes.clear)          nextQ[i] = 1'b0;
      else if (strobes.load)      nextQ[i] = busIn[i];
      else if (strobes.shiftUp)   nextQ[i] = fromBelow[i];
      else if (strobes.shiftDown) nextQ[i] = fromAbove[i];
      else                        nextQ[i] = regQ[i];
    end
  end

  always_ff @(posedge clk) begin
    regQ <= nextQ;
  end

  assign tapLow  = regQ[0];
  assign tapHigh = regQ[MSB];

endmodule

// File: rtl/bidir_shift_reg.sv
module bidir_shift_reg
  import bsr_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       modeSel,
  input  logic             serInLsb,
  input  logic             serInMsb,
  input  logic             enANeg,
  input  logic             enBNeg,
  input  logic [WIDTH-1:0] busIn,
  output logic [WIDTH-1:0] busOut,
  output logic             busDrive,
  output logic             tapLow,
  output logic             tapHigh
);

  strobe_t          strobes;
  logic [WIDTH-1:0] regQ;

  bsr_ctrl u_ctrl (
    .rstN     (rstN),
    .modeSel  (modeSel),
    .enANeg   (enANeg),
    .enBNeg   (enBNeg),
    .strobes  (strobes),
    .busDrive (busDrive)
  );

  bsr_dpath #(.WIDTH(WIDTH)) u_dpath (
    .clk      (clk),
    .strobes  (strobes),
    .busIn    (busIn),
    .serInLsb (serInLsb),
    .serInMsb (serInMsb),
    .regQ     (regQ),
    .tapLow   (tapLow),
    .tapHigh  (tapHigh)
  );

  assign busOut = regQ;

endmodule

// File: rtl/bsr_checker.sv
module bsr_checker #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic [1:0]       modeSel,
  input logic             serInLsb,
  input logic             serInMsb,
  input logic             enANeg,
  input logic             enBNeg,
  input logic [WIDTH-1:0] busIn,
  input logic [WIDTH-1:0] busOut,
  input logic             busDrive,
  input logic             tapLow,
  input logic             tapHigh
);

  // Set once a reset edge has been seen; register contents are unknown before.
  logic armed;
  always_ff @(posedge clk) begin
    if (!rstN) armed <= 1'b1;
  end

  p_clear_r1: assert property (@(posedge clk)
    !rstN |=> busOut == '0);

  p_load_r2: assert property (@(posedge clk) disable iff (armed !== 1'b1)
    (rstN && modeSel == 2'b11) |=> busOut == $past(busIn));

  p_shift_up_r3: assert property (@(posedge clk) disable iff (armed !== 1'b1)
    (rstN && modeSel == 2'b01) |=>
      busOut == {$past(busOut[WIDTH-2:0]), $past(serInLsb)});

  p_shift_down_r4: assert property (@(posedge clk) disable iff (armed !== 1'b1)
    (rstN && modeSel == 2'b10) |=>
      busOut == {$past(serInMsb), $past(busOut[WIDTH-1:1])});

  p_hold_r5: assert property (@(posedge clk) disable iff (armed !== 1'b1)
    (rstN && modeSel == 2'b00) |=> $stable(busOut));

  p_enable_off_r6: assert property (@(posedge clk) disable iff (armed !== 1'b1)
    (enANeg || enBNeg) |-> !busDrive);

  p_load_release_r7: assert property (@(posedge clk) disable iff (armed !== 1'b1)
    (modeSel == 2'b11) |-> !busDrive);

  p_drive_on_r7: assert property (@(posedge clk) disable iff (armed !== 1'b1)
    (!enANeg && !enBNeg && modeSel != 2'b11) |-> busDrive);

  p_taps_r9: assert property (@(posedge clk) disable iff (armed !== 1'b1)
    (tapLow == busOut[0]) && (tapHigh == busOut[WIDTH-1]));

endmodule

bind bidir_shift_reg bsr_checker #(.WIDTH(WIDTH)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .modeSel  (modeSel),
  .serInLsb (serInLsb),
  .serInMsb (serInMsb),
  .enANeg   (enANeg),
  .enBNeg   (enBNeg),
  .busIn    (busIn),
  .busOut   (busOut),
  .busDrive (busDrive),
  .tapLow   (tapLow),
  .tapHigh  (tapHigh)
);

// File: tb/test_bidir_shift_reg.sv
module test_bidir_shift_reg;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  int checks   = 0;
  int failures = 0;

  // Single instance with a modelled bus
  logic       rstN, sLsb, sMsb, enA, enB, tbDrv;
  logic [1:0] mode;
  logic [7:0] tbBus, bIn, bOut;
  logic       bDrv, tLow, tHigh;
  logic [7:0] model;

  assign bIn = bDrv ? bOut : (tbDrv ? tbBus : 8'h00);

  bidir_shift_reg #(.WIDTH(8)) i_bidir_shift_reg (
    .clk(clk), .rstN(rstN), .modeSel(mode), .serInLsb(sLsb), .serInMsb(sMsb),
    .enANeg(enA), .enBNeg(enB), .busIn(bIn), .busOut(bOut), .busDrive(bDrv),
    .tapLow(tLow), .tapHigh(tHigh)
  );

  // Chained pair: low half holds bits 7..0, high half bits 15..8
  logic        cRstN, cSerLsb, cSerMsb;
  logic [1:0]  cMode;
  logic [15:0] cData;
  logic [7:0]  loIn, hiIn, loOut, hiOut;
  logic        loDrv, hiDrv, loTapL, loTapH, hiTapL, hiTapH;
  logic [15:0] cModel;

  assign loIn = loDrv ? loOut : cData[7:0];
  assign hiIn = hiDrv ? hiOut : cData[15:8];

  bidir_shift_reg #(.WIDTH(8)) i_lowHalf (
    .clk(clk), .rstN(cRstN), .modeSel(cMode), .serInLsb(cSerLsb), .serInMsb(hiTapL),
    .enANeg(1'b0), .enBNeg(1'b0), .busIn(loIn), .busOut(loOut), .busDrive(loDrv),
    .tapLow(loTapL), .tapHigh(loTapH)
  );

  bidir_shift_reg #(.WIDTH(8)) i_highHalf (
    .clk(clk), .rstN(cRstN), .modeSel(cMode), .serInLsb(loTapH), .serInMsb(cSerMsb),
    .enANeg(1'b0), .enBNeg(1'b0), .busIn(hiIn), .busOut(hiOut), .busDrive(hiDrv),
    .tapLow(hiTapL), .tapHigh(hiTapH)
  );

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check8(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check1(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic check16(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_mode(logic [1:0] m, logic inLsb, logic inMsb);
    mode = m; sLsb = inLsb; sMsb = inMsb;
    tick();
    if (!rstN)          model = 8'h00;
    else if (m == 2'b11) model = tbBus;
    else if (m == 2'b01) model = {model[6:0], inLsb};
    else if (m == 2'b10) model = {inMsb, model[7:1]};
  endtask

  task automatic t_reset();
    rstN = 1'b0; tbDrv = 1'b1; tbBus = 8'hFF;
    run_mode(2'b11, 1'b1, 1'b1);
    check8("R1 clear while load selected", bOut, 8'h00);
    rstN = 1'b1; run_mode(2'b11, 1'b0, 1'b0);
    rstN = 1'b0; run_mode(2'b01, 1'b1, 1'b1);
    check8("R1 clear overrides shift", bOut, 8'h00);
    rstN = 1'b1;
  endtask

  task automatic t_load_shift();
    enA = 1'b0; enB = 1'b0; tbDrv = 1'b1; tbBus = 8'hA5;
    mode = 2'b11; #1;
    check1("R7 drive released in load mode", bDrv, 1'b0);
    run_mode(2'b11, 1'b0, 1'b0);
    check8("R2 load A5", bOut, model);
    check8("R2 load A5 literal", bOut, 8'hA5);
    tbDrv = 1'b0;
    run_mode(2'b01, 1'b1, 1'b0);
    check8("R3 shift up with 1", bOut, 8'h4B);
    run_mode(2'b01, 1'b0, 1'b1);
    check8("R3 shift up with 0", bOut, model);
    run_mode(2'b10, 1'b1, 1'b0);
    check8("R4 shift down with 0", bOut, model);
    run_mode(2'b10, 1'b0, 1'b1);
    check8("R4 shift down with 1", bOut, model);
    check1("R7 drive on in shift mode", bDrv, 1'b1);
    check1("R9 low tap", tLow, model[0]);
    check1("R9 high tap", tHigh, model[7]);
  endtask

  task automatic t_hold();
    tbDrv = 1'b1; tbBus = 8'h3C;
    run_mode(2'b11, 1'b0, 1'b0);
    enA = 1'b1; tbBus = 8'hFF;
    for (int k = 0; k < 3; k++) run_mode(2'b00, 1'b1, 1'b1);
    check8("R5 hold ignores serial and bus", bOut, 8'h3C);
    enA = 1'b0; mode = 2'b00; #1;
    check1("R7 drive on in hold", bDrv, 1'b1);
  endtask

  task automatic t_enables();
    mode = 2'b00;
    enA = 1'b1; enB = 1'b0; #1;
    check1("R6 enable A high", bDrv, 1'b0);
    enA = 1'b0; enB = 1'b1; #1;
    check1("R6 enable B high", bDrv, 1'b0);
    enA = 1'b1; enB = 1'b1; mode = 2'b10; #1;
    check1("R6 both high", bDrv, 1'b0);
    // Operations keep running with drivers off
    tbDrv = 1'b1; tbBus = 8'h96;
    run_mode(2'b11, 1'b0, 1'b0);
    check8("R8 load with drivers off", bOut, 8'h96);
    tbDrv = 1'b0;
    run_mode(2'b01, 1'b1, 1'b0);
    check8("R8 shift with drivers off", bOut, 8'h2D);
    check1("R9 high tap with drivers off", tHigh, 1'b0);
    check1("R9 low tap with drivers off", tLow, 1'b1);
    rstN = 1'b0; run_mode(2'b00, 1'b0, 1'b0); rstN = 1'b1;
    check8("R8 reset with drivers off", bOut, 8'h00);
    enA = 1'b0; enB = 1'b0;
  endtask

  task automatic t_cascade();
    logic [15:0] pat = 16'hC3A1;
    cRstN = 1'b0; cMode = 2'b00; tick(); cRstN = 1'b1;
    cData = 16'h0F00; cMode = 2'b11; tick(); cModel = 16'h0F00;
    check16("R10 chained load", {hiOut, loOut}, cModel);
    cMode = 2'b01;
    for (int k = 0; k < 16; k++) begin
      cSerLsb = pat[k]; tick();
      cModel = {cModel[14:0], pat[k]};
    end
    check16("R10 chained shift up 16", {hiOut, loOut}, cModel);
    check16("R10 chained shift up pattern", {hiOut, loOut},
            {pat[0], pat[1], pat[2], pat[3], pat[4], pat[5], pat[6], pat[7],
             pat[8], pat[9], pat[10], pat[11], pat[12], pat[13], pat[14], pat[15]});
    cMode = 2'b10;
    for (int k = 0; k < 16; k++) begin
      cSerMsb = ~pat[k]; tick();
      cModel = {~pat[k], cModel[15:1]};
      if (k == 7) check16("R10 chained shift down midway", {hiOut, loOut}, cModel);
    end
    check16("R10 chained shift down 16", {hiOut, loOut}, cModel);
    check1("R10 end tap", hiTapH, cModel[15]);
  endtask

  initial begin
    rstN = 1'b1; mode = 2'b00; sLsb = 1'b0; sMsb = 1'b0; enA = 1'b0; enB = 1'b0;
    tbDrv = 1'b0; tbBus = 8'h00; model = 8'h00;
    cRstN = 1'b1; cMode = 2'b00; cSerLsb = 1'b0; cSerMsb = 1'b0; cData = 16'h0; cModel = 16'h0;
    @(negedge clk);
    t_reset();
    t_load_shift();
    t_hold();
    t_enables();
    t_cascade();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule